// File: doc/BRIEF.md
# Glitch-Checked Register File

This block is a flip-flop register file with one write port and two read ports. It is hardened against fault injection. With the `SECURE` parameter set, every read address is decoded into a one-hot select vector. That vector drives an AND-OR multiplexer, so no read path ever indexes storage with a binary number. The write address and write strobe are decoded the same way into a per-register write-enable vector.

A small checker watches each of the three decoded vectors. If any of them takes an illegal shape, the checker raises `alert_o` in the same cycle. The block makes no attempt at repair: a corrupted select still drives the mux and the storage exactly as it stands. Bit flips in the binary addresses before decoding are not caught here; an external lockstep scheme is expected to cover them.

With `SECURE` cleared, the read decoders, the checkers and the one-hot muxes are not built. Reads then use a plain indexed mux and the alert stays low. Three fault-mask inputs XOR a pattern into the decoded vectors, so corruption can be injected on purpose. Register 0 is hardwired to zero.

Top module: `hard_regfile`

## Requirements
- R1: A low `rst_ni` at a rising clock edge clears every register to zero. Each register then reads as zero until it is written.
- R2: When `we_i` is high, `waddr_i` is non-zero and `fi_mask_w_i` is zero, `wdata_i` is stored at the rising edge. From the following cycle it appears on any read port addressing that register.
- R3: Register 0 always reads as zero. A write aimed at address 0 changes no register.
- R4: The two read ports are independent: each returns, combinationally, the register named by its own address in the same cycle.
- R5: A read of the register being written in the same cycle returns the old contents. The new value is visible only after the edge.
- R6: With `SECURE` set, a read select (bit i = `raddr == i`, XOR its fault mask) with zero bits set, or with two or more bits set, raises `alert_o` combinationally in that cycle.
- R7: With `SECURE` set, the write-enable vector (bit i = `we_i && waddr_i == i`, XOR `fi_mask_w_i`) must have exactly one bit set while `we_i` is high and no bit set while `we_i` is low. Any other shape raises `alert_o` in that cycle.
- R8: Detected violations are not corrected. A read returns the bitwise OR of every register whose select bit is set, which is zero when none is set. A write stores `wdata_i` into every non-zero register whose write-enable bit is set.
- R9: With legal addresses and all fault masks zero, `alert_o` stays low.
- R10: With `SECURE` cleared, reads index storage directly, the fault masks have no effect on data or writes, and `alert_o` is always low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| we_i | input | 1 | Write strobe |
| waddr_i | input | ADDR_W | Write register index |
| wdata_i | input | DATA_W | Write data |
| raddr_a_i | input | ADDR_W | Read port A index |
| raddr_b_i | input | ADDR_W | Read port B index |
| fi_mask_a_i | input | NUM_REGS | Fault pattern XORed into the port A select |
| fi_mask_b_i | input | NUM_REGS | Fault pattern XORed into the port B select |
| fi_mask_w_i | input | NUM_REGS | Fault pattern XORed into the write-enable vector |
| rdata_a_o | output | DATA_W | Read port A data |
| rdata_b_o | output | DATA_W | Read port B data |
| alert_o | output | 1 | Major alert: some decoded vector is malformed |

## Verification
A write and two reads can fall in the same cycle, and a fault can hit a read select and the write-enable vector at once. The bench provokes both cases. It issues writes whose address matches one or both read addresses, and it drives read masks and a write mask together, some while the strobe is low. A behavioural model judges each cycle: reads see the pre-edge contents ORed over the corrupted select, the alert is the OR of the three shape tests, and the corrupted write lands in every selected register at the edge.

// File: rtl/hard_regfile_pkg.sv
// Package: shared helpers for the glitch-checked register file.
// Assumes vectors are passed in as packed bit vectors of up to 1024 bits.
package hard_regfile_pkg;

    localparam int unsigned MAX_VEC_W = 1024;

    // Returns true when exactly one bit of v is set (v & (v-1) clears the lowest set bit).
    function automatic logic is_onehot(input logic [MAX_VEC_W-1:0] v);
        return (v != '0) && ((v & (v - 1'b1)) == '0);
    endfunction

endpackage

// File: rtl/onehot_dec.sv
// Module: onehot_dec
// Turns a binary index into a one-hot vector gated by an enable.
// Assumes N <= 2**AW; indices at or beyond N yield an all-zero vector.
module onehot_dec #(
    parameter int unsigned N  = 32,
    parameter int unsigned AW = 5
) (
    input  logic          en_i,
    input  logic [AW-1:0] idx_i,
    output logic [N-1:0]  vec_o
);

    for (genvar i = 0; i < N; i++) begin : gen_bit
        // Bit i is set only when enabled and the index equals i.
        assign vec_o[i] = en_i && (idx_i == AW'(i));
    end

endmodule

// File: rtl/onehot_mux.sv
// Module: onehot_mux
// AND-OR multiplexer: ORs together every word whose select bit is set.
// Assumes nothing about the select; an all-zero select returns zero.
module onehot_mux #(
    parameter int unsigned N = 32,
    parameter int unsigned W = 32
) (
    input  logic [N-1:0]        sel_i,
    input  logic [N-1:0][W-1:0] data_i,
    output logic [W-1:0]        data_o
);

    // Accumulate masked words across all inputs.
    always_comb begin
        data_o = '0;
        for (int i = 0; i < N; i++) begin
            data_o = data_o | (data_i[i] & {W{sel_i[i]}});
        end
    end

endmodule

// File: rtl/onehot_chk.sv
// Module: onehot_chk
// Flags a vector that breaks its expected shape: exactly one bit set when
// expect_one_i is high, no bit set otherwise. Purely combinational.
module onehot_chk
    import hard_regfile_pkg::*;
#(
    parameter int unsigned N = 32
) (
    input  logic [N-1:0] vec_i,
    input  logic         expect_one_i,
    output logic         err_o
);

    logic [MAX_VEC_W-1:0] vec_ext;

    // Widen to the helper width.
    assign vec_ext = MAX_VEC_W'(vec_i);

    // Compare the observed shape with the expected one.
    assign err_o = expect_one_i ? !is_onehot(vec_ext) : (vec_i != '0);

endmodule

// File: rtl/regfile_store.sv
// Module: regfile_store
// Flop storage for N words of W bits; entry 0 is never written.
// Assumes we_vec_i is already decoded; several set bits write several words.
module regfile_store #(
    parameter int unsigned N = 32,
    parameter int unsigned W = 32
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [N-1:0]        we_vec_i,
    input  logic [W-1:0]        wdata_i,
    output logic [N-1:0][W-1:0] rf_q
);

    logic unused_we0;

    // Entry 0 is hardwired, so its enable bit is not consumed.
    assign unused_we0 = we_vec_i[0];

    // Clear on reset, else load every enabled entry from 1 upward.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rf_q <= '0;
        end else begin
            for (int i = 1; i < N; i++) begin
                if (we_vec_i[i]) begin
                    rf_q[i] <= wdata_i;
                end
            end
        end
    end

endmodule

// File: rtl/hard_regfile.sv
// Module: hard_regfile
// Two-read, one-write flop register file. With SECURE set, reads go through
// one-hot selects and AND-OR muxes, and three checkers feed a combinational
// alert. Faults are injected by XOR masks after decoding. Errors are flagged,
// never corrected. Binary-address upsets before decoding are not covered.
module hard_regfile #(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned DATA_W   = 32,
    parameter bit          SECURE   = 1'b1,
    localparam int unsigned ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                we_i,
    input  logic [ADDR_W-1:0]   waddr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [ADDR_W-1:0]   raddr_a_i,
    input  logic [ADDR_W-1:0]   raddr_b_i,
    input  logic [NUM_REGS-1:0] fi_mask_a_i,
    input  logic [NUM_REGS-1:0] fi_mask_b_i,
    input  logic [NUM_REGS-1:0] fi_mask_w_i,
    output logic [DATA_W-1:0]   rdata_a_o,
    output logic [DATA_W-1:0]   rdata_b_o,
    output logic                alert_o
);

    logic [NUM_REGS-1:0]             wen_raw;
    logic [NUM_REGS-1:0]             wen_vec;
    logic [NUM_REGS-1:0][DATA_W-1:0] rf_q;

    // Write-side decoder, present in both variants.
    onehot_dec #(.N(NUM_REGS), .AW(ADDR_W)) u_dec_w (
        .en_i  (we_i),
        .idx_i (waddr_i),
        .vec_o (wen_raw)
    );

    regfile_store #(.N(NUM_REGS), .W(DATA_W)) u_store (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_vec_i (wen_vec),
        .wdata_i  (wdata_i),
        .rf_q     (rf_q)
    );

    if (SECURE) begin : gen_secure
        logic [NUM_REGS-1:0] sel_a_raw, sel_b_raw, sel_a, sel_b;
        logic                err_a, err_b, err_w;

        // Inject faults after decoding.
        assign sel_a   = sel_a_raw ^ fi_mask_a_i;
        assign sel_b   = sel_b_raw ^ fi_mask_b_i;
        assign wen_vec = wen_raw ^ fi_mask_w_i;

        onehot_dec #(.N(NUM_REGS), .AW(ADDR_W)) u_dec_a (
            .en_i (1'b1), .idx_i (raddr_a_i), .vec_o (sel_a_raw)
        );
        onehot_dec #(.N(NUM_REGS), .AW(ADDR_W)) u_dec_b (
            .en_i (1'b1), .idx_i (raddr_b_i), .vec_o (sel_b_raw)
        );

        onehot_mux #(.N(NUM_REGS), .W(DATA_W)) u_mux_a (
            .sel_i (sel_a), .data_i (rf_q), .data_o (rdata_a_o)
        );
        onehot_mux #(.N(NUM_REGS), .W(DATA_W)) u_mux_b (
            .sel_i (sel_b), .data_i (rf_q), .data_o (rdata_b_o)
        );

        onehot_chk #(.N(NUM_REGS)) u_chk_a (
            .vec_i (sel_a), .expect_one_i (1'b1), .err_o (err_a)
        );
        onehot_chk #(.N(NUM_REGS)) u_chk_b (
            .vec_i (sel_b), .expect_one_i (1'b1), .err_o (err_b)
        );
        onehot_chk #(.N(NUM_REGS)) u_chk_w (
            .vec_i (wen_vec), .expect_one_i (we_i), .err_o (err_w)
        );

        // Aggregate all checker flags into the major alert.
        assign alert_o = err_a | err_b | err_w;

        // R6: a malformed read select must be reported in its own cycle.
        p_bad_sel_a_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($countones(sel_a) != 1) |-> alert_o);
        p_bad_sel_b_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($countones(sel_b) != 1) |-> alert_o);
        // R7: write-enable shape must match the strobe.
        p_bad_wen_hi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (we_i && $countones(wen_vec) != 1) |-> alert_o);
        p_bad_wen_lo_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!we_i && wen_vec != '0) |-> alert_o);
        // R8: an empty select returns zero rather than a repaired value.
        p_empty_sel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (sel_a == '0) |-> (rdata_a_o == '0));
        // R9: clean inputs keep the alert low.
        p_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (fi_mask_a_i == '0 && fi_mask_b_i == '0 && fi_mask_w_i == '0 &&
             32'(raddr_a_i) < NUM_REGS && 32'(raddr_b_i) < NUM_REGS &&
             (!we_i || 32'(waddr_i) < NUM_REGS)) |-> !alert_o);
    end else begin : gen_plain
        logic unused_fi;

        // Masks are not used without hardening.
        assign unused_fi = ^{fi_mask_a_i, fi_mask_b_i, fi_mask_w_i};
        assign wen_vec   = wen_raw;
        // Conventional indexed reads.
        assign rdata_a_o = rf_q[raddr_a_i];
        assign rdata_b_o = rf_q[raddr_b_i];
        assign alert_o   = 1'b0;
    end

    // R1: first cycle out of reset reads zero on a clean select.
    p_reset_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(!rst_ni) && fi_mask_a_i == '0) |-> (rdata_a_o == '0));
    // R3: register 0 reads zero through a clean select.
    p_zero_reg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (raddr_a_i == '0 && fi_mask_a_i == '0) |-> (rdata_a_o == '0));
    // R2: a clean write is visible on port A in the following cycle.
    p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && waddr_i != '0 && fi_mask_w_i == '0) |=>
        (!(raddr_a_i == $past(waddr_i) && fi_mask_a_i == '0) ||
         rdata_a_o == $past(wdata_i)));

endmodule

// File: tb/hard_regfile_tb_top.sv
// Bench: drives a hardened and a plain instance with the same stimulus and
// compares both against behavioural models on every clock.
module hard_regfile_tb_top;

    localparam int NR = 32;
    localparam int DW = 32;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic          we_i = 1'b0;
    logic [4:0]    waddr_i = '0, raddr_a_i = '0, raddr_b_i = '0;
    logic [DW-1:0] wdata_i = '0;
    logic [NR-1:0] fi_mask_a_i = '0, fi_mask_b_i = '0, fi_mask_w_i = '0;
    logic [DW-1:0] rdata_a_o, rdata_b_o, p_rdata_a, p_rdata_b;
    logic          alert_o, p_alert;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [DW-1:0] m_sec [NR];
    logic [DW-1:0] m_pln [NR];

    always #4 clk_i = ~clk_i;

    hard_regfile #(.NUM_REGS(NR), .DATA_W(DW), .SECURE(1'b1)) dut_i (
        .clk_i, .rst_ni, .we_i, .waddr_i, .wdata_i, .raddr_a_i, .raddr_b_i,
        .fi_mask_a_i, .fi_mask_b_i, .fi_mask_w_i,
        .rdata_a_o, .rdata_b_o, .alert_o
    );

    hard_regfile #(.NUM_REGS(NR), .DATA_W(DW), .SECURE(1'b0)) dut_plain_i (
        .clk_i, .rst_ni, .we_i, .waddr_i, .wdata_i, .raddr_a_i, .raddr_b_i,
        .fi_mask_a_i, .fi_mask_b_i, .fi_mask_w_i,
        .rdata_a_o (p_rdata_a), .rdata_b_o (p_rdata_b), .alert_o (p_alert)
    );

    function automatic int popc(input logic [NR-1:0] v);
        int c = 0;
        for (int i = 0; i < NR; i++) c += int'(v[i]);
        return c;
    endfunction

    function automatic logic [DW-1:0] sec_read(input logic [NR-1:0] sel);
        logic [DW-1:0] r = '0;
        for (int i = 1; i < NR; i++) if (sel[i]) r |= m_sec[i];
        return r;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One cycle: drive, check combinational outputs, then commit the model at the edge.
    task automatic step(input logic we, input logic [4:0] wa, input logic [DW-1:0] wd,
                        input logic [4:0] ra, input logic [4:0] rb,
                        input logic [NR-1:0] ma, input logic [NR-1:0] mb,
                        input logic [NR-1:0] mw, input string req);
        logic [NR-1:0] sa, sb, wv;
        logic          exp_alert;
        we_i = we; waddr_i = wa; wdata_i = wd; raddr_a_i = ra; raddr_b_i = rb;
        fi_mask_a_i = ma; fi_mask_b_i = mb; fi_mask_w_i = mw;
        #2;
        sa = (NR'(1) << ra) ^ ma;
        sb = (NR'(1) << rb) ^ mb;
        wv = (we ? (NR'(1) << wa) : NR'(0)) ^ mw;
        exp_alert = (popc(sa) != 1) || (popc(sb) != 1) ||
                    (we ? (popc(wv) != 1) : (wv != '0));
        chk(req, "rdata_a", rdata_a_o, sec_read(sa));
        chk(req, "rdata_b", rdata_b_o, sec_read(sb));
        chk(req, "alert", DW'(alert_o), DW'(exp_alert));
        chk("R10", "plain_a", p_rdata_a, m_pln[ra]);
        chk("R10", "plain_b", p_rdata_b, m_pln[rb]);
        chk("R10", "plain_alert", DW'(p_alert), '0);
        @(posedge clk_i);
        for (int i = 1; i < NR; i++) if (wv[i]) m_sec[i] = wd;
        if (we && wa != 0) m_pln[wa] = wd;
        @(negedge clk_i);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] lcg;
        for (int i = 0; i < NR; i++) begin m_sec[i] = '0; m_pln[i] = '0; end
        // Preload junk, then reset clears it (R1).
        rst_ni = 1'b1;
        @(negedge clk_i);
        we_i = 1'b1; waddr_i = 5'd9; wdata_i = 32'hDEAD_BEEF;
        @(negedge clk_i);
        rst_ni = 1'b0; we_i = 1'b0;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        for (int r = 0; r < NR; r++) step(0, 0, 0, 5'(r), 5'(NR - 1 - r), 0, 0, 0, "R1");

        // R2: fill every register, then read back.
        for (int i = 1; i < NR; i++)
            step(1, 5'(i), 32'hA500_0000 + 32'(i * 32'h0101), 5'(i - 1), 0, 0, 0, 0, "R2");
        for (int i = 0; i < NR; i++) step(0, 0, 0, 5'(i), 5'(i), 0, 0, 0, "R2");

        // R3: writes to register 0 are dropped.
        step(1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 1, 0, 0, 0, "R3");

        // R4: independent ports.
        for (int i = 0; i < 16; i++)
            step(0, 0, 0, 5'((i * 7) % NR), 5'((i * 13 + 3) % NR), 0, 0, 0, "R4");

        // R5: same-cycle read of the written register returns old data.
        step(1, 5, 32'h1234_5678, 5, 5, 0, 0, 0, "R5");
        step(0, 0, 0, 5, 5, 0, 0, 0, "R5");

        // R6: every single-bit fault on each read select.
        for (int b = 0; b < NR; b++) step(0, 0, 0, 5'(b % 7), 3, NR'(1) << b, 0, 0, "R6");
        for (int b = 0; b < NR; b++) step(0, 0, 0, 2, 5'(b % 5), 0, NR'(1) << b, 0, "R6");

        // R8: multi-bit read faults OR registers together.
        step(0, 0, 0, 8, 4, 32'h0000_0F00, 32'h8000_0011, 0, "R8");
        step(0, 0, 0, 1, 1, 32'hFFFF_FFFF, 32'h0000_0003, 0, "R8");

        // R7: write-vector faults with strobe high and low, combined with read faults.
        for (int b = 0; b < NR; b++)
            step(1, 5'(b ^ 1), 32'hC0DE_0000 + 32'(b), 5'(b ^ 1), 5'(b), NR'(1) << b, 0,
                 NR'(1) << b, "R7");
        for (int b = 0; b < NR; b += 3)
            step(0, 0, 32'h7700_0000 + 32'(b), 5'(b), 0, 0, 0, NR'(1) << b, "R7");
        step(1, 6, 32'hBEEF_0006, 6, 7, 0, 0, 32'h0000_3080, "R8");
        for (int i = 0; i < NR; i++) step(0, 0, 0, 5'(i), 5'(NR - 1 - i), 0, 0, 0, "R8");

        // R9: clean mixed traffic, alert must stay low.
        lcg = 32'h1357_9BDF;
        for (int i = 0; i < 200; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            step(lcg[31], lcg[4:0], lcg ^ 32'h5A5A_A5A5, lcg[9:5], lcg[14:10], 0, 0, 0, "R9");
        end

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule